// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a real-time clock and calendar placed inside a bytewide memory map. A one-cycle pulse once per second advances a set of live BCD counters for seconds, minutes, hours (24-hour), day of week, date, month, year and century. The calendar knows real month lengths and the full Gregorian leap-year rule, so no outside correction is needed. The eight highest byte addresses of the map hold the time registers. Every lower address is ordinary RAM.

Software never touches the live counters directly. Reads return a snapshot copy, which is refreshed from the counters after each tick, but only when no read is in progress. A read therefore never sees a half-carried time, and counting goes on unchanged. Writes to a time register land in a holding copy, and the live counter takes that value at the next tick.

A power-good input gates all bus access. While it is low, reads return 0xFF and writes are dropped. When it returns, a hold-off of `REC_CYC` clock cycles must pass before access resumes. The map width is set by `ADDR_W`. A value of 13 gives the full 8K x 8 space, and the default of 10 keeps the RAM small.

The bus has no back-pressure. A request is a single cycle with `bus_cs` high, and it is always taken. Read data appears on `bus_rdata` one clock later and holds until the next read.

Top module: `rtc_membus`

## Requirements
- R1: The time registers sit at the eight top addresses of the map, in ascending address order: seconds, minutes, hours, day of week, date, month, year, century. After reset they read 00, 00, 00, 01, 01, 01, 00, 20 (BCD), and `bus_rdata` is 0x00.
- R2: Each tick adds one second. Seconds and minutes wrap from 59 to 00 and carry, and hours wrap from 23 to 00 and carry into the day.
- R3: A day carry moves day of week through 1..7 and back to 1. It moves the date to 01 of the next month after the last day of the current month: 30 days for months 04, 06, 09 and 11, and 31 days for the other months except February.
- R4: February has 29 days when the year is a multiple of 4, except when the year is 00 and the century is not a multiple of 4. So 2000 and 2024 are leap years, and 2100 and 2023 are not.
- R5: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and increments the century, and century 99 wraps to 00.
- R6: Every address below the top eight is a RAM byte that reads back the last value written to it. Read data for any address appears one cycle after the request.
- R7: Reads return the snapshot. While reads are issued back to back, the snapshot does not change. The refresh that follows a tick waits for the first cycle with no read in progress.
- R8: A write to a time register does not change what that register reads before the next tick. At that tick the register takes the written value in place of its own increment, while the other registers still advance.
- R9: No tick is lost while reads, writes or a power lockout coincide with it.
- R10: While `pwr_ok` is low, reads return 0xFF, and writes to RAM or time registers have no effect.
- R11: After `pwr_ok` rises, requests on the first `REC_CYC` clock edges are blocked, and the next edge is accepted. A drop of `pwr_ok` during the hold-off restarts the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| pwr_ok | input | 1 | High while supply is above the fail threshold |
| bus_cs | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after a read request |

## Verification
Read data is due one clock after the request edge. The bench drives on falling edges and samples `bus_rdata` at the following falling edge. A tick updates the live counters on its own edge and the snapshot on the next idle edge, so the bench leaves a further idle cycle after each tick before reading the time. For the power hold-off, the bench holds a read request on every edge after `pwr_ok` rises. It expects 0xFF through edge `REC_CYC` and stored data on edge `REC_CYC+1`. It repeats this with a mid-count drop of `pwr_ok` to show the restart.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG   = 8;
  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HR   = 2;
  localparam int IX_DOW  = 3;
  localparam int IX_DATE = 4;
  localparam int IX_MON  = 5;
  localparam int IX_YR   = 6;
  localparam int IX_CEN  = 7;

  typedef logic [NREG-1:0][7:0] rtc_regs_t;

  // century 20, year 00, Jan 01, day 1, 00:00:00
  localparam rtc_regs_t RTC_RESET = {8'h20, 8'h00, 8'h01, 8'h01,
                                     8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
  import rtc_pkg::*;
(
  input  rtc_regs_t cur,
  output rtc_regs_t nxt
);
  logic [6:0] yr_b, cen_b;
  logic       leap;
  logic [7:0] last_day;
  logic       c_sec, c_min, c_hr, c_date, c_mon, c_yr;

  always_comb begin
    yr_b     = bcd_to_bin(cur[IX_YR]);
    cen_b    = bcd_to_bin(cur[IX_CEN]);
    leap     = (yr_b[1:0] == 2'b00) && ((yr_b != 7'd0) || (cen_b[1:0] == 2'b00));
    last_day = month_last(cur[IX_MON], leap);
    nxt      = cur;

    c_sec = (cur[IX_SEC] == 8'h59);
    nxt[IX_SEC] = c_sec ? 8'h00 : bcd_inc(cur[IX_SEC]);

    c_min = c_sec && (cur[IX_MIN] == 8'h59);
    if (c_sec) nxt[IX_MIN] = (cur[IX_MIN] == 8'h59) ? 8'h00 : bcd_inc(cur[IX_MIN]);

    c_hr = c_min && (cur[IX_HR] == 8'h23);
    if (c_min) nxt[IX_HR] = (cur[IX_HR] == 8'h23) ? 8'h00 : bcd_inc(cur[IX_HR]);

    if (c_hr) nxt[IX_DOW] = (cur[IX_DOW] == 8'h07) ? 8'h01 : cur[IX_DOW] + 8'h01;

    c_date = c_hr && (cur[IX_DATE] == last_day);
    if (c_hr) nxt[IX_DATE] = (cur[IX_DATE] == last_day) ? 8'h01 : bcd_inc(cur[IX_DATE]);

    c_mon = c_date && (cur[IX_MON] == 8'h12);
    if (c_date) nxt[IX_MON] = (cur[IX_MON] == 8'h12) ? 8'h01 : bcd_inc(cur[IX_MON]);

    c_yr = c_mon && (cur[IX_YR] == 8'h99);
    if (c_mon) nxt[IX_YR] = (cur[IX_YR] == 8'h99) ? 8'h00 : bcd_inc(cur[IX_YR]);

    if (c_yr) nxt[IX_CEN] = (cur[IX_CEN] == 8'h99) ? 8'h00 : bcd_inc(cur[IX_CEN]);
  end
endmodule

// File: rtl/rtc_power_gate.sv
module rtc_power_gate #(
  parameter int REC_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic acc_en
);
  localparam int CNT_W = $clog2(REC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REC_CYC);

  logic [CNT_W-1:0] holdoff;

  always_ff @(posedge clk) begin
    if (!rst_n)          holdoff <= CNT_LOAD;
    else if (!pwr_ok)    holdoff <= CNT_LOAD;
    else if (holdoff != '0) holdoff <= holdoff - 1'b1;
  end

  assign acc_en = pwr_ok && (holdoff == '0);

  // R11: the edge at which power-good returns is never an accepted one
  p_holdoff_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ok) |-> !acc_en);
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int AW    = 10,
  parameter int DEPTH = 1016
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtc_membus.sv
module rtc_membus
  import rtc_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int REC_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              pwr_ok,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam int IX_W     = $clog2(NREG);
  localparam int RAM_DEPTH = (1 << ADDR_W) - NREG;
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(RAM_DEPTH);

  logic            acc_en, is_reg, rd_now, wr_ok;
  logic [IX_W-1:0] reg_ix;
  logic [7:0]      ram_rd;
  rtc_regs_t       live, hold, snap, stepped;
  logic [NREG-1:0] wpend, wpend_nxt;
  logic            refresh_pend;

  assign is_reg = (bus_addr >= REG_BASE);
  assign reg_ix = bus_addr[IX_W-1:0];
  assign rd_now = bus_cs && !bus_we;
  assign wr_ok  = bus_cs && bus_we && acc_en;

  rtc_power_gate #(.REC_CYC(REC_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .acc_en(acc_en)
  );

  rtc_ram #(.AW(ADDR_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .wr_en(wr_ok && !is_reg), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(ram_rd)
  );

  rtc_calendar_step u_step (.cur(live), .nxt(stepped));

  always_comb begin
    wpend_nxt = tick_1hz ? '0 : wpend;
    if (wr_ok && is_reg) wpend_nxt[reg_ix] = 1'b1;
  end

  // live counters and staged writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= RTC_RESET;
      hold  <= '0;
      wpend <= '0;
    end else begin
      if (tick_1hz) begin
        for (int i = 0; i < NREG; i++)
          live[i] <= wpend[i] ? hold[i] : stepped[i];
      end
      if (wr_ok && is_reg) hold[reg_ix] <= bus_wdata;
      wpend <= wpend_nxt;
    end
  end

  // snapshot refresh, deferred while reads are in progress
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap         <= RTC_RESET;
      refresh_pend <= 1'b0;
    end else begin
      if (refresh_pend && !rd_now) snap <= live;
      refresh_pend <= tick_1hz || (refresh_pend && rd_now);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (rd_now) bus_rdata <= !acc_en ? 8'hFF : (is_reg ? snap[reg_ix] : ram_rd);
  end

  // R10: a read while power is low always yields 0xFF
  p_lock_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_we && !pwr_ok) |=> (bus_rdata == 8'hFF));

  // R10: a write while power is low stages nothing
  p_lock_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we && !pwr_ok && !tick_1hz) |=> $stable(wpend));

  // R7: the snapshot never moves under a read
  p_snap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_we) |=> $stable(snap));

  // R9: the live time moves only on a tick
  p_live_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1hz |=> $stable(live));

  // R2: seconds wrap from 59 to 00
  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && live[IX_SEC] == 8'h59 && !wpend[IX_SEC]) |=> (live[IX_SEC] == 8'h00));
endmodule

// File: tb/rtc_membus_tb.sv
module rtc_membus_tb;
  localparam int AW   = 10;
  localparam int REC  = 8;
  localparam int BASE = (1 << AW) - 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick_1hz = 1'b0, pwr_ok = 1'b1;
  logic bus_cs = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int mt [8];  // binary model: sec,min,hr,dow,date,mon,yr,cen

  always #2 clk = ~clk;

  rtc_membus #(.ADDR_W(AW), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_ok(pwr_ok),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic int dim(input int mon, input int cen, input int yr);
    bit leap;
    leap = (yr % 4 == 0) && (yr != 0 || cen % 4 == 0);
    if (mon == 2) return leap ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    mt[0]++;
    if (mt[0] == 60) begin mt[0] = 0; mt[1]++;
      if (mt[1] == 60) begin mt[1] = 0; mt[2]++;
        if (mt[2] == 24) begin mt[2] = 0;
          mt[3] = (mt[3] == 7) ? 1 : mt[3] + 1;
          mt[4]++;
          if (mt[4] > dim(mt[5], mt[7], mt[6])) begin mt[4] = 1; mt[5]++;
            if (mt[5] == 13) begin mt[5] = 1; mt[6]++;
              if (mt[6] == 100) begin mt[6] = 0; mt[7] = (mt[7] + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input int a, output logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = AW'(a);
    @(negedge clk); d = bus_rdata; bus_cs = 0;
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_we = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    @(negedge clk);
  endtask

  task automatic tick_model();
    pulse_tick(); model_step();
  endtask

  task automatic load_time(input int c, input int y, input int mo, input int d,
                           input int w, input int h, input int mi, input int s);
    int v [8];
    v = '{s, mi, h, w, d, mo, y, c};
    for (int i = 0; i < 8; i++) do_write(BASE + i, bcd(v[i]));
    pulse_tick();
    for (int i = 0; i < 8; i++) mt[i] = v[i];
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      do_read(BASE + i, d);
      chk(d, bcd(mt[i]), $sformatf("%s reg%0d", tag, i));
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    int cy [6][2];
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_rdata, 8'h00, "R1 reset rdata");
    repeat (REC + 2) @(negedge clk);

    // R1 reset values and map order
    mt = '{0, 0, 0, 1, 1, 1, 0, 20};
    check_all("R1 reset");

    // R6 RAM read back, including the byte just below the registers
    do_write(0, 8'hA5);
    do_write(333, 8'h3C);
    do_write(BASE - 1, 8'h5A);
    do_read(0, d);        chk(d, 8'hA5, "R6 ram 0");
    do_read(333, d);      chk(d, 8'h3C, "R6 ram mid");
    do_read(BASE - 1, d); chk(d, 8'h5A, "R6 ram top");
    do_read(BASE, d);     chk(d, 8'h00, "R1 sec at base");

    // R2 seconds/minutes/hours sweep
    load_time(20, 24, 6, 15, 3, 22, 58, 40);
    for (int k = 0; k < 90; k++) begin
      tick_model();
      do_read(BASE + 0, d); chk(d, bcd(mt[0]), "R2 sec");
      do_read(BASE + 1, d); chk(d, bcd(mt[1]), "R2 min");
      do_read(BASE + 2, d); chk(d, bcd(mt[2]), "R2 hr");
    end
    load_time(20, 24, 6, 15, 3, 23, 59, 58);
    tick_model(); tick_model(); check_all("R2 day carry");

    // R3 R4 R5 month-end sweep over leap and century cases
    cy = '{'{20, 0}, '{21, 0}, '{20, 24}, '{20, 23}, '{19, 99}, '{99, 99}};
    for (int j = 0; j < 6; j++) begin
      for (int m = 1; m <= 12; m++) begin
        load_time(cy[j][0], cy[j][1], m, dim(m, cy[j][0], cy[j][1]),
                  (m % 7) + 1, 23, 59, 59);
        tick_model();
        check_all($sformatf("R3 R4 R5 c%0d y%0d m%0d", cy[j][0], cy[j][1], m));
      end
    end
    load_time(20, 24, 2, 28, 7, 23, 59, 59);
    tick_model(); check_all("R4 2024-02-28");
    load_time(21, 0, 2, 28, 7, 23, 59, 59);
    tick_model(); check_all("R4 2100-02-28");

    // R8 staged write replaces only its own register
    load_time(20, 30, 5, 10, 2, 0, 5, 59);
    do_write(BASE + 1, 8'h45);
    do_read(BASE + 1, d); chk(d, 8'h05, "R8 before tick");
    tick_model(); mt[1] = 45;
    check_all("R8 after tick");

    // R7 held read across a tick keeps the old snapshot
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = AW'(BASE);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk(bus_rdata, bcd(mt[0]), "R7 frozen");
    end
    bus_cs = 0;
    @(negedge clk);
    model_step();
    do_read(BASE, d); chk(d, bcd(mt[0]), "R7 refreshed");

    // R9 ticks coinciding with bus traffic
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); tick_1hz = 1; bus_cs = 1; bus_we = (k % 2 == 0);
      bus_addr = AW'(k % 2 == 0 ? 50 : BASE); bus_wdata = 8'(k);
      @(negedge clk); tick_1hz = 0; bus_cs = 0; bus_we = 0;
      model_step();
    end
    @(negedge clk);
    check_all("R9 no lost ticks");

    // R10 lockout
    @(negedge clk); pwr_ok = 0;
    do_read(0, d);        chk(d, 8'hFF, "R10 ram read locked");
    do_read(BASE + 2, d); chk(d, 8'hFF, "R10 reg read locked");
    do_write(0, 8'h11);
    do_write(BASE, 8'h33);
    tick_model(); tick_model();
    @(negedge clk); pwr_ok = 1;
    repeat (REC + 2) @(negedge clk);
    do_read(0, d); chk(d, 8'hA5, "R10 ram write ignored");
    tick_model();
    check_all("R10 R9 reg write ignored, ticks kept");

    // R11 hold-off length
    @(negedge clk); pwr_ok = 0;
    @(negedge clk); pwr_ok = 1; bus_cs = 1; bus_we = 0; bus_addr = '0;
    for (int k = 1; k <= REC + 1; k++) begin
      @(negedge clk);
      chk(bus_rdata, (k <= REC) ? 8'hFF : 8'hA5, $sformatf("R11 edge %0d", k));
    end
    // R11 restart on a mid-count drop
    pwr_ok = 0;
    @(negedge clk); pwr_ok = 1;
    repeat (REC / 2) @(negedge clk);
    pwr_ok = 0;
    @(negedge clk); pwr_ok = 1;
    for (int k = 1; k <= REC + 1; k++) begin
      @(negedge clk);
      chk(bus_rdata, (k <= REC) ? 8'hFF : 8'hA5, $sformatf("R11 restart edge %0d", k));
    end
    bus_cs = 0;

    done = 1;
    finish_run();
  end
endmodule